// File: doc/BRIEF.md
# CAVLC Coefficient Level Decoder

This block turns the level codewords of one 4×4 residual block into signed coefficient values. A decode begins with a one-cycle `start_i` pulse that carries the block's total non-zero count and trailing-ones count. The count of levels to decode is their difference. The block also selects the starting code table from these two counts.

Each `bits_valid_i` pulse presents a window of upcoming stream bits, most significant bit first. One cycle later the block returns one signed level and the number of bits it used. The caller advances its bit pointer by that amount before it sends the next window.

The decode runs in two stages. In the first stage, a per-prefix row gives the remainder width for the current table. In the second stage, the prefix, the remainder and the table form a level code. That code maps onto the interleaved +1, −1, +2, −2, … sequence. Prefixes of 16 or more zeros are escape codes, and their value is formed arithmetically. Between levels the block adapts its table index from 0 up to 6 and shows it on `tbl_o`.

Top module: `cavlc_lvl_dec`

## Requirements
- R1: One cycle after `start_i`, `tbl_o` is 1 when the total count exceeds 10 and the trailing-ones count is below 3; otherwise `tbl_o` is 0.
- R2: The prefix is the number of leading zeros before the first 1 in `bits_i`. For a prefix below 14, or below 15 when the table is nonzero, the remainder is the next `tbl_o` bits. The level code is then (prefix << table) + remainder. `len_o` equals prefix + 1 + remainder width.
- R3: In table 0, a prefix of 14 takes a 4-bit remainder, giving code 14 + remainder. A prefix of 15 takes a 12-bit remainder in every table; its code is (15 << table) + remainder, with a further 15 added in table 0.
- R4: A prefix P of 16 or more takes a P−3 bit remainder. Its code is the prefix-15 code plus 2^(P−3) − 4096.
- R5: When the trailing-ones count is below 3, the first level of the block has 2 added to its code.
- R6: An even code k gives level k/2 + 1. An odd code k gives level −(k+1)/2.
- R7: After each level, table 0 first becomes 1. A table t from 1 to 5 then advances by one when the level's magnitude exceeds 3·2^(t−1). The table never goes above 6.
- R8: Each `bits_valid_i` pulse during a decode yields exactly one `level_valid_o` pulse on the next cycle. `bits_valid_i` outside a decode produces no output.
- R9: `done_o` pulses together with the last level. When the level count is zero, `done_o` pulses one cycle after `start_i` and no level is produced.
- R10: During reset, `busy_o`, `level_valid_o`, `done_o` and `tbl_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new block |
| total_coeff_i | input | CNT_W | Total non-zero coefficients of the block |
| trailing_ones_i | input | 2 | Trailing ±1 count of the block |
| bits_valid_i | input | 1 | A bit window is presented |
| bits_i | input | WIN | Upcoming stream bits, MSB first |
| busy_o | output | 1 | Levels remain to be decoded |
| level_valid_o | output | 1 | `level_o` and `len_o` are valid |
| level_o | output | MAX_PREFIX | Signed decoded level |
| len_o | output | clog2(WIN+1) | Bits consumed by this level |
| tbl_o | output | 3 | Current level code table |
| done_o | output | 1 | Last level emitted |

## Verification
The table selected by `start_i` appears on `tbl_o` one cycle later. Each level, its length and the adapted table appear one cycle after the `bits_valid_i` pulse that carried the codeword, and `done_o` arrives in that same cycle for the last level. The bench drives every input on a falling edge and samples on the next falling edge. This places exactly one register stage between stimulus and check, and the bench confirms that no output moves in the cycle after an ignored pulse. Expected codewords come from an arithmetic encoder in the bench. The bench sweeps first-level values under four start conditions, builds long blocks that push the table to its limit, and encodes the table-0 and escape boundaries explicitly.

// File: rtl/cavlc_lvl_pkg.sv
package cavlc_lvl_pkg;
  localparam int unsigned NUM_TBL = 7;
  localparam int unsigned TBL_W   = 3;
  localparam int unsigned NSLOT   = 1 << TBL_W;
  typedef logic [TBL_W-1:0] tbl_t;
  localparam tbl_t TBL_TOP = tbl_t'(NUM_TBL - 1);
endpackage

// File: rtl/cavlc_lvl_lzc.sv
module cavlc_lvl_lzc #(
  parameter int unsigned W   = 32,
  parameter int unsigned LZW = 6
) (
  input  logic [W-1:0]   bits_i,
  output logic [LZW-1:0] lz_o
);
  // lowest-to-highest scan: the highest set bit wins
  always_comb begin
    lz_o = LZW'(W);
    for (int i = 0; i < int'(W); i++) begin
      if (bits_i[i]) lz_o = LZW'(int'(W) - 1 - i);
    end
  end
endmodule

// File: rtl/cavlc_lvl_sel.sv
// Stage 1: prefix-indexed row giving remainder width per table.
module cavlc_lvl_sel
  import cavlc_lvl_pkg::*;
#(
  parameter int unsigned MAX_PREFIX = 16,
  parameter int unsigned PW         = 5,
  parameter int unsigned SSW        = 4
) (
  input  logic [PW-1:0]  lz_i,
  input  tbl_t           tbl_i,
  output logic [SSW-1:0] suf_sz_o
);
  localparam int unsigned NROW = 1 << PW;

  logic [SSW-1:0] sz_t0   [NROW];
  logic           is_long [NROW];

  for (genvar p = 0; p < int'(NROW); p++) begin : g_row
    localparam int PC = (p > int'(MAX_PREFIX)) ? int'(MAX_PREFIX) : p;
    if (PC >= 15) begin : g_long
      assign sz_t0[p]   = SSW'(PC - 3);
      assign is_long[p] = 1'b1;
    end else if (PC == 14) begin : g_p14
      assign sz_t0[p]   = SSW'(4);
      assign is_long[p] = 1'b0;
    end else begin : g_short
      assign sz_t0[p]   = '0;
      assign is_long[p] = 1'b0;
    end
  end

  always_comb begin
    if (tbl_i == '0 || is_long[lz_i]) suf_sz_o = sz_t0[lz_i];
    else                              suf_sz_o = SSW'(tbl_i);
  end
endmodule

// File: rtl/cavlc_lvl_map.sv
// Stage 2: prefix + remainder -> level code -> interleaved signed level.
module cavlc_lvl_map
  import cavlc_lvl_pkg::*;
#(
  parameter int unsigned PW = 5,
  parameter int unsigned SW = 13,
  parameter int unsigned CW = 16
) (
  input  logic [PW-1:0]        lz_i,
  input  tbl_t                 tbl_i,
  input  logic [SW-1:0]        suf_i,
  input  logic                 adj_i,
  output logic signed [CW-1:0] level_o,
  output logic [CW-1:0]        mag_o
);
  logic [CW-1:0] code;
  logic [PW-1:0] pfx_cap;

  always_comb begin
    pfx_cap = (lz_i >= PW'(15)) ? PW'(15) : lz_i;
    code    = (CW'(pfx_cap) << tbl_i) + CW'(suf_i);
    if (lz_i >= PW'(15) && tbl_i == '0) code = code + CW'(15);
    // escape: arithmetic extension of the prefix-15 range
    if (lz_i >= PW'(16)) code = code + (CW'(1) << (lz_i - PW'(3))) - CW'(4096);
    if (adj_i) code = code + CW'(2);
    mag_o   = code[0] ? ((code + CW'(1)) >> 1) : ((code >> 1) + CW'(1));
    level_o = code[0] ? -$signed(mag_o) : $signed(mag_o);
  end
endmodule

// File: rtl/cavlc_lvl_adapt.sv
module cavlc_lvl_adapt
  import cavlc_lvl_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  tbl_t          tbl_i,
  input  logic [CW-1:0] mag_i,
  output tbl_t          tbl_o
);
  logic [NSLOT-1:0] adv;
  tbl_t             base;

  for (genvar t = 0; t < int'(NSLOT); t++) begin : g_thr
    if (t == 0 || t >= int'(NUM_TBL) - 1) begin : g_hold
      assign adv[t] = 1'b0;
    end else begin : g_cmp
      assign adv[t] = mag_i > CW'(3 << (t - 1));
    end
  end

  always_comb begin
    base  = (tbl_i == '0) ? tbl_t'(1) : tbl_i;
    tbl_o = adv[base] ? base + tbl_t'(1) : base;
  end
endmodule

// File: rtl/cavlc_lvl_dec.sv
module cavlc_lvl_dec
  import cavlc_lvl_pkg::*;
#(
  parameter int unsigned MAX_PREFIX = 16,
  parameter int unsigned WIN        = 32,
  parameter int unsigned CNT_W      = 5
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic [CNT_W-1:0]             total_coeff_i,
  input  logic [1:0]                   trailing_ones_i,
  input  logic                         bits_valid_i,
  input  logic [WIN-1:0]               bits_i,
  output logic                         busy_o,
  output logic                         level_valid_o,
  output logic signed [MAX_PREFIX-1:0] level_o,
  output logic [$clog2(WIN+1)-1:0]     len_o,
  output logic [2:0]                   tbl_o,
  output logic                         done_o
);
  localparam int unsigned LZW  = $clog2(WIN + 1);
  localparam int unsigned PW   = $clog2(MAX_PREFIX + 1);
  localparam int unsigned SW   = MAX_PREFIX - 3;
  localparam int unsigned SSW  = $clog2(SW + 1);
  localparam int unsigned CW   = MAX_PREFIX;

  logic [LZW-1:0]        lz_raw;
  logic [PW-1:0]         lz;
  logic [SSW-1:0]        suf_sz;
  logic [LZW:0]          pfx_len;
  logic [WIN-1:0]        after_pfx, suf_full;
  logic [SW-1:0]         suf_val;
  logic [LZW-1:0]        len_d;
  logic signed [CW-1:0]  level_d;
  logic [CW-1:0]         mag_d;
  tbl_t                  tbl_q, tbl_nxt;

  logic                  busy_q, first_q, adj_q, vld_q, done_q;
  logic [CNT_W-1:0]      cnt_q, cnt_start;
  logic signed [CW-1:0]  level_q;
  logic [LZW-1:0]        len_q;

  cavlc_lvl_lzc #(.W(WIN), .LZW(LZW)) u_lzc (
    .bits_i (bits_i),
    .lz_o   (lz_raw)
  );

  assign lz = (lz_raw > LZW'(MAX_PREFIX)) ? PW'(MAX_PREFIX) : lz_raw[PW-1:0];

  cavlc_lvl_sel #(.MAX_PREFIX(MAX_PREFIX), .PW(PW), .SSW(SSW)) u_sel (
    .lz_i     (lz),
    .tbl_i    (tbl_q),
    .suf_sz_o (suf_sz)
  );

  // drop prefix and separator, then right-align the remainder
  always_comb begin
    pfx_len   = (LZW+1)'(lz) + (LZW+1)'(1);
    after_pfx = bits_i << pfx_len;
    suf_full  = after_pfx >> (WIN - 32'(suf_sz));
    suf_val   = suf_full[SW-1:0];
    len_d     = LZW'(lz) + LZW'(suf_sz) + LZW'(1);
  end

  cavlc_lvl_map #(.PW(PW), .SW(SW), .CW(CW)) u_map (
    .lz_i    (lz),
    .tbl_i   (tbl_q),
    .suf_i   (suf_val),
    .adj_i   (adj_q & first_q),
    .level_o (level_d),
    .mag_o   (mag_d)
  );

  cavlc_lvl_adapt #(.CW(CW)) u_adapt (
    .tbl_i (tbl_q),
    .mag_i (mag_d),
    .tbl_o (tbl_nxt)
  );

  assign cnt_start = total_coeff_i - CNT_W'(trailing_ones_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      first_q <= 1'b0;
      adj_q   <= 1'b0;
      vld_q   <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      tbl_q   <= '0;
      level_q <= '0;
      len_q   <= '0;
    end else if (start_i) begin
      busy_q  <= (cnt_start != '0);
      done_q  <= (cnt_start == '0);
      cnt_q   <= cnt_start;
      first_q <= 1'b1;
      adj_q   <= (trailing_ones_i != 2'd3);
      tbl_q   <= (total_coeff_i > CNT_W'(10) && trailing_ones_i != 2'd3) ? tbl_t'(1) : '0;
      vld_q   <= 1'b0;
    end else if (busy_q && bits_valid_i) begin
      vld_q   <= 1'b1;
      level_q <= level_d;
      len_q   <= len_d;
      tbl_q   <= tbl_nxt;
      first_q <= 1'b0;
      cnt_q   <= cnt_q - CNT_W'(1);
      busy_q  <= (cnt_q != CNT_W'(1));
      done_q  <= (cnt_q == CNT_W'(1));
    end else begin
      vld_q   <= 1'b0;
      done_q  <= 1'b0;
    end
  end

  assign busy_o        = busy_q;
  assign level_valid_o = vld_q;
  assign level_o       = level_q;
  assign len_o         = len_q;
  assign tbl_o         = tbl_q;
  assign done_o        = done_q;
endmodule

// File: rtl/cavlc_lvl_dec_chk.sv
module cavlc_lvl_dec_chk #(
  parameter int unsigned MAX_PREFIX = 16,
  parameter int unsigned WIN        = 32
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         start_i,
  input logic                         busy_o,
  input logic                         level_valid_o,
  input logic signed [MAX_PREFIX-1:0] level_o,
  input logic [$clog2(WIN+1)-1:0]     len_o,
  input logic [2:0]                   tbl_o,
  input logic                         done_o
);
  // R7
  tbl_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_o <= 3'd6);

  // R7
  tbl_left_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_valid_o |-> tbl_o != 3'd0);

  // R7
  tbl_monotonic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !start_i) |=> tbl_o >= $past(tbl_o));

  // R8
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> !level_valid_o);

  // R6
  level_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_valid_o |-> level_o != '0);

  // R2
  len_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_valid_o |-> len_o != '0);

  // R9
  done_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

bind cavlc_lvl_dec cavlc_lvl_dec_chk #(.MAX_PREFIX(MAX_PREFIX), .WIN(WIN)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .busy_o        (busy_o),
  .level_valid_o (level_valid_o),
  .level_o       (level_o),
  .len_o         (len_o),
  .tbl_o         (tbl_o),
  .done_o        (done_o)
);

// File: tb/cavlc_lvl_dec_tb.sv
module cavlc_lvl_dec_tb;
  localparam int unsigned MP  = 16;
  localparam int unsigned WIN = 32;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start = 1'b0;
  logic [4:0]         tc = '0;
  logic [1:0]         t1 = '0;
  logic               bv = 1'b0;
  logic [WIN-1:0]     bits = '0;
  logic               busy, lvalid, done;
  logic signed [MP-1:0] level;
  logic [5:0]         len;
  logic [2:0]         tbl;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cavlc_lvl_dec #(.MAX_PREFIX(MP), .WIN(WIN), .CNT_W(5)) u_dut (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start),
    .total_coeff_i (tc), .trailing_ones_i (t1),
    .bits_valid_i (bv), .bits_i (bits),
    .busy_o (busy), .level_valid_o (lvalid), .level_o (level),
    .len_o (len), .tbl_o (tbl), .done_o (done)
  );

  task automatic check_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bench-side encoder: level -> codeword bits (MSB aligned), length, prefix
  task automatic encode(input int lvl, input int sl, input bit adj,
                        output logic [31:0] w, output int len_e, output int p);
    int code, sb, s;
    code = (lvl > 0) ? 2*lvl - 2 : -2*lvl - 1;
    if (adj) code -= 2;
    if (sl == 0) begin
      if (code < 14)             begin p = code; sb = 0;  s = 0; end
      else if (code < 30)        begin p = 14;   sb = 4;  s = code - 14; end
      else if (code < 30 + 4096) begin p = 15;   sb = 12; s = code - 30; end
      else                       begin p = 16;   sb = 13; s = code - 30 - 4096; end
    end else begin
      if (code < (15 << sl))                 begin p = code >> sl; sb = sl; s = code & ((1 << sl) - 1); end
      else if (code - (15 << sl) < 4096)     begin p = 15; sb = 12; s = code - (15 << sl); end
      else                                   begin p = 16; sb = 13; s = code - (15 << sl) - 4096; end
    end
    len_e = p + 1 + sb;
    w = 32'(((longint'(1) << sb) | longint'(s)) << (32 - len_e));
    w = w | (32'h5A5A_A5A5 & ((32'h1 << (32 - len_e)) - 32'h1));
  endtask

  function automatic int next_tbl(input int sl, input int lvl);
    int ns, a;
    ns = (sl == 0) ? 1 : sl;
    a = (lvl < 0) ? -lvl : lvl;
    if (ns < 6 && a > (3 << (ns - 1))) ns++;
    return ns;
  endfunction

  task automatic run_block(input int tcv, input int t1v, input int lv[16]);
    int cnt, sl, len_e, p;
    logic [31:0] w;
    bit adj;
    string tag;
    @(negedge clk);
    start = 1'b1; tc = 5'(tcv); t1 = 2'(t1v);
    @(negedge clk);
    start = 1'b0;
    cnt = tcv - t1v;
    sl = (tcv > 10 && t1v < 3) ? 1 : 0;
    check_eq("R1 initial table", int'(tbl), sl);
    if (cnt == 0) begin
      check_eq("R9 done on empty block", int'(done), 1);
      check_eq("R9 not busy on empty block", int'(busy), 0);
      return;
    end
    check_eq("R9 busy after start", int'(busy), 1);
    for (int j = 0; j < cnt; j++) begin
      adj = (j == 0) && (t1v < 3);
      encode(lv[j], sl, adj, w, len_e, p);
      bits = w; bv = 1'b1;
      @(negedge clk);
      bv = 1'b0;
      if (p >= 16)                    tag = "R4 escape level";
      else if (sl == 0 && p >= 14)    tag = "R3 table0 long prefix level";
      else if (adj)                   tag = "R5 first level offset";
      else                            tag = "R6 level mapping";
      check_eq("R8 one level per pulse", int'(lvalid), 1);
      check_eq(tag, int'(level), lv[j]);
      check_eq("R2 consumed length", int'(len), len_e);
      sl = next_tbl(sl, lv[j]);
      check_eq("R7 table adaptation", int'(tbl), sl);
      check_eq("R9 done with last level", int'(done), (j == cnt - 1) ? 1 : 0);
    end
    @(negedge clk);
    check_eq("R8 no output after block", int'(lvalid), 0);
    check_eq("R9 idle after block", int'(busy), 0);
  endtask

  task automatic fill_seq(input int v, output int lv[16]);
    int mag;
    lv[0] = v;
    for (int j = 1; j < 16; j++) begin
      mag = 1 + ((v*v*7 + j*j*13 + 1000) % (j*60 + 3));
      lv[j] = ((v + j) & 1) ? -mag : mag;
    end
  endtask

  initial begin
    int lv[16];
    int mtc[4];
    int mt1[4];
    int xv[15];
    int av[4];
    mtc = '{11, 16, 5, 13};
    mt1 = '{0, 3, 1, 3};
    xv  = '{7, -7, 8, -8, 15, -15, 16, 2063, -2063, 2064, -2064, 3000, -3000, 1, -1};
    av  = '{2100, -2100, 9, -9};

    // R10 reset state
    #1;
    check_eq("R10 busy in reset", int'(busy), 0);
    check_eq("R10 valid in reset", int'(lvalid), 0);
    check_eq("R10 done in reset", int'(done), 0);
    check_eq("R10 table in reset", int'(tbl), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8 window while idle is ignored
    @(negedge clk);
    bits = 32'h8000_0000; bv = 1'b1;
    @(negedge clk);
    bv = 1'b0;
    check_eq("R8 idle pulse ignored", int'(lvalid), 0);
    check_eq("R8 idle pulse no done", int'(done), 0);

    // R9 empty blocks
    fill_seq(1, lv);
    run_block(3, 3, lv);
    run_block(0, 0, lv);

    // sweep first levels under four start conditions
    for (int m = 0; m < 4; m++) begin
      for (int v = -40; v <= 40; v++) begin
        if (v == 0) continue;
        if (mt1[m] < 3 && (v == 1 || v == -1)) continue;
        fill_seq(v, lv);
        run_block(mtc[m], mt1[m], lv);
      end
    end

    // R3/R4 table-0 boundaries without offset
    foreach (xv[i]) begin
      lv[0] = xv[i];
      run_block(4, 3, lv);
    end
    // R4/R5 escape and boundaries with first-level offset
    foreach (av[i]) begin
      lv[0] = av[i];
      run_block(2, 1, lv);
    end
    // R4 escape from table 1
    fill_seq(2500, lv);
    run_block(11, 0, lv);
    fill_seq(-2500, lv);
    run_block(11, 2, lv);

    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule